// File: doc/BRIEF.md
# Radix-4 on-the-fly result and multiple generator

This block builds the quotient or square root of a radix-4 digit-recurrence unit in plain binary while signed digits in {-2, -1, 0, +1, +2} arrive one per iteration. No redundant-to-binary conversion is needed at the end. Two registers are kept. The first is the result itself, Q. The second is the two's-complement negation of Q. This second register equals the bitwise inverse of Q-1ulp, where the ulp is the weight of the last digit, with the ones below the last digit position cleared.

The same two registers also feed a generator. It forms, in the same cycle, the value that the remainder datapath adds for each of the five candidate digits. That value is the negated multiple, given as an inverted word plus a carry-in bit. In root mode it is built only from shifts, a single marker bit, OR and inversion, with no adder. In divide mode it is built from the divisor. The remainder datapath can use the five candidates speculatively. It can also use the single candidate that the one-hot digit selects.

A one-hot marker shows where the next digit goes. It starts at the top digit position on reset or on `init_i` and moves two bits toward the LSB with each accepted digit. With the default of NDIG=8 digits the result is 16 bits wide, and each multiple is 19 bits wide in two's complement.

Top module: `otf_root_gen`

## Requirements
- R1: After reset, or in the cycle after `init_i` is high, `q_pos_o` and `q_negn_o` are zero and `done_o` is low. `init_i` takes priority over `step_i`.
- R2: Digit k counts from 1 and has weight 4^(NDIG-k) in the integer reading of the result. After each accepted digit, `q_pos_o` equals the exact sum of digit times weight, modulo 2^W. The one-hot `digit_i` encoding is: bit0 = -2, bit1 = -1, bit2 = 0, bit3 = +1, bit4 = +2.
- R3: `q_negn_o` always equals (-Q) mod 2^W. While a run is in progress, `q_pos_o + q_negn_o` is therefore zero modulo 2^W.
- R4: In root mode (`mode_i`=1), let m be the weight of the next digit (0 once the run is done). For c in {+1, +2}, `mult_o[c+2] + cin_o[c+2]` equals -c*(2Q + c*m) mod 2^MW, and `cin_o` is 1.
- R5: In root mode, for c in {-1, -2}, `mult_o[c+2] + cin_o[c+2]` equals -c*(2Q + c*m) mod 2^MW, and `cin_o` is 1.
- R6: The zero-digit slot `mult_o[2]` is all zeros and `cin_o[2]` is 0 in both modes.
- R7: In divide mode (`mode_i`=0), `mult_o[c+2] + cin_o[c+2]` equals -c*D mod 2^MW for c in {-2, -1, +1, +2}. `cin_o` is 1 for positive c and 0 for negative c.
- R8: `sel_mult_o` and `sel_cin_o` equal the slot that the one-hot `digit_i` names. `digit_i` must be one-hot whenever a digit is presented.
- R9: After NDIG accepted digits `done_o` is high. Further `step_i` pulses leave `q_pos_o` and `q_negn_o` unchanged until the next init.
- R10: With `step_i` and `init_i` both low, the result registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Clear result, restart marker at top digit |
| step_i | input | 1 | Accept `digit_i` this cycle |
| mode_i | input | 1 | 1 = square root, 0 = divide |
| digit_i | input | 5 | One-hot signed digit (bit0 = -2 ... bit4 = +2) |
| divisor_i | input | W | Divisor D for divide-mode multiples |
| q_pos_o | output | W | Result Q in binary |
| q_negn_o | output | W | Negated result, (-Q) mod 2^W |
| done_o | output | 1 | All digit positions filled |
| mult_o | output | 5 x MW | Inverted negated multiple per candidate digit |
| cin_o | output | 5 | Carry-in bit per candidate |
| sel_mult_o | output | MW | Multiple chosen by `digit_i` |
| sel_cin_o | output | 1 | Carry-in chosen by `digit_i` |

## Verification
The bench drives sequences in which a negative digit follows a positive prefix. Such a sequence forces the plus-form register to reload from the minus form. A wrong borrow digit there shows up as an off-by-one-ulp result, and a wrong mask shows up as stray low ones in `q_negn_o`, which breaks the negation identity. Runs of all +2 digits and of +1 followed by all -2 digits stress the marker bits. A mis-placed marker OR in the negative multiples gives a result that is wrong by a multiple of m. The very first digit is checked while the negated register is still zero, which catches a sign extension taken from anything other than a zero test. Extra steps after completion, and an init held together with a step, catch a design that keeps appending past the last position or lets the step win over the restart.

// File: rtl/otf_pkg.sv
package otf_pkg;
  // one-hot digit slot positions
  localparam int DIG_M2 = 0;
  localparam int DIG_M1 = 1;
  localparam int DIG_Z  = 2;
  localparam int DIG_P1 = 3;
  localparam int DIG_P2 = 4;
  localparam int NSLOT  = 5;

  typedef enum logic {
    MODE_DIV  = 1'b0,
    MODE_ROOT = 1'b1
  } otf_mode_e;
endpackage

// File: rtl/otf_marker.sv
module otf_marker #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         init_i,
  input  logic         adv_i,
  output logic [W-1:0] mark_o,
  output logic         done_o
);
  localparam logic [W-1:0] FIRST = {2'b01, {(W-2){1'b0}}};

  logic [W-1:0] mark_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                mark_q <= FIRST;
    else if (init_i)            mark_q <= FIRST;
    else if (adv_i && |mark_q)  mark_q <= mark_q >> 2;
  end

  assign mark_o = mark_q;
  assign done_o = ~|mark_q;

  p_marker_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mark_q));

  p_marker_move_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && adv_i && |mark_q) |=> (mark_q == ($past(mark_q) >> 2)));
endmodule

// File: rtl/otf_regs.sv
module otf_regs
  import otf_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             adv_i,
  input  logic [NSLOT-1:0] digit_i,
  input  logic [W-1:0]     mark_i,
  output logic [W-1:0]     qp_o,
  output logic [W-1:0]     qn_o
);
  logic [W-1:0] qp_q, qn_q;
  logic [W+1:0] m4, m4_low;
  logic [W-1:0] mask_old, mask_new, qm_cur, m_lo, m_hi;
  logic [W-1:0] qp_nx, qm_nx, qn_nx;

  // recover Q- : bits below the previous digit are zero in Q-
  assign m4       = {mark_i, 2'b00};
  assign m4_low   = m4 - {{(W+1){1'b0}}, 1'b1};
  assign mask_old = ~m4_low[W-1:0];
  assign qm_cur   = ~qn_q & mask_old;
  assign mask_new = ~(mark_i - {{(W-1){1'b0}}, 1'b1});
  assign m_lo     = mark_i;
  assign m_hi     = mark_i << 1;

  // one-hot digit steers the append sources directly
  always_comb begin
    qp_nx = ({W{digit_i[DIG_P2]}} & (qp_q | m_hi))
          | ({W{digit_i[DIG_P1]}} & (qp_q | m_lo))
          | ({W{digit_i[DIG_Z]}}  &  qp_q)
          | ({W{digit_i[DIG_M1]}} & (qm_cur | m_hi | m_lo))
          | ({W{digit_i[DIG_M2]}} & (qm_cur | m_hi));
    qm_nx = ({W{digit_i[DIG_P2]}} & (qp_q | m_lo))
          | ({W{digit_i[DIG_P1]}} &  qp_q)
          | ({W{digit_i[DIG_Z]}}  & (qm_cur | m_hi | m_lo))
          | ({W{digit_i[DIG_M1]}} & (qm_cur | m_hi))
          | ({W{digit_i[DIG_M2]}} & (qm_cur | m_lo));
    qn_nx = ~qm_nx & mask_new;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qp_q <= '0;
      qn_q <= '0;
    end else if (init_i) begin
      qp_q <= '0;
      qn_q <= '0;
    end else if (adv_i) begin
      qp_q <= qp_nx;
      qn_q <= qn_nx;
    end
  end

  assign qp_o = qp_q;
  assign qn_o = qn_q;

  p_init_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (qp_q == '0 && qn_q == '0));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && !adv_i) |=> ($stable(qp_q) && $stable(qn_q)));
endmodule

// File: rtl/otf_mult.sv
module otf_mult
  import otf_pkg::*;
#(
  parameter int W  = 16,
  parameter int MW = W + 3
) (
  input  logic                        mode_i,
  input  logic [W-1:0]                qp_i,
  input  logic [W-1:0]                qn_i,
  input  logic [W-1:0]                mark_i,
  input  logic [W-1:0]                divisor_i,
  output logic [NSLOT-1:0][MW-1:0]    mult_o,
  output logic [NSLOT-1:0]            cin_o
);
  localparam int XW = MW - W;

  logic [MW-1:0] qp_x, qn_x, m_x, d_x;
  logic          root;

  assign root = (otf_mode_e'(mode_i) == MODE_ROOT);
  assign qp_x = {{XW{1'b0}}, qp_i};
  // -Q is negative unless Q is zero
  assign qn_x = {{XW{|qn_i}}, qn_i};
  assign m_x  = {{XW{1'b0}}, mark_i};
  assign d_x  = {{XW{1'b0}}, divisor_i};

  assign mult_o[DIG_Z] = '0;
  assign cin_o[DIG_Z]  = 1'b0;

  for (genvar g = 1; g <= 2; g++) begin : g_mag
    logic [MW-1:0] root_pos, root_neg, div_pos, div_neg;
    assign root_pos = ~((qp_x << g) | (m_x << (2 * (g - 1))));
    assign root_neg = ~((qn_x << g) | (m_x << (2 * (g - 1))));
    assign div_pos  = ~(d_x << (g - 1));
    assign div_neg  =  (d_x << (g - 1));
    assign mult_o[DIG_Z + g] = root ? root_pos : div_pos;
    assign mult_o[DIG_Z - g] = root ? root_neg : div_neg;
    assign cin_o[DIG_Z + g]  = 1'b1;
    assign cin_o[DIG_Z - g]  = root;
  end
endmodule

// File: rtl/otf_root_gen.sv
module otf_root_gen
  import otf_pkg::*;
#(
  parameter int NDIG = 8,
  parameter int W    = 2 * NDIG,
  parameter int MW   = W + 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     init_i,
  input  logic                     step_i,
  input  logic                     mode_i,
  input  logic [NSLOT-1:0]         digit_i,
  input  logic [W-1:0]             divisor_i,
  output logic [W-1:0]             q_pos_o,
  output logic [W-1:0]             q_negn_o,
  output logic                     done_o,
  output logic [NSLOT-1:0][MW-1:0] mult_o,
  output logic [NSLOT-1:0]         cin_o,
  output logic [MW-1:0]            sel_mult_o,
  output logic                     sel_cin_o
);
  logic [W-1:0] mark;
  logic         done, adv;
  logic [W-1:0] neg_sum;

  assign adv = step_i & ~done & ~init_i;

  otf_marker #(.W(W)) u_marker (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (init_i),
    .adv_i  (adv),
    .mark_o (mark),
    .done_o (done)
  );

  otf_regs #(.W(W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .init_i  (init_i),
    .adv_i   (adv),
    .digit_i (digit_i),
    .mark_i  (mark),
    .qp_o    (q_pos_o),
    .qn_o    (q_negn_o)
  );

  otf_mult #(.W(W), .MW(MW)) u_mult (
    .mode_i    (mode_i),
    .qp_i      (q_pos_o),
    .qn_i      (q_negn_o),
    .mark_i    (mark),
    .divisor_i (divisor_i),
    .mult_o    (mult_o),
    .cin_o     (cin_o)
  );

  always_comb begin
    sel_mult_o = '0;
    sel_cin_o  = 1'b0;
    for (int s = 0; s < NSLOT; s++) begin
      sel_mult_o = sel_mult_o | ({MW{digit_i[s]}} & mult_o[s]);
      sel_cin_o  = sel_cin_o  | (digit_i[s] & cin_o[s]);
    end
  end

  assign done_o  = done;
  assign neg_sum = q_pos_o + q_negn_o;

  p_digit_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !done && !init_i) |-> $onehot(digit_i));

  p_negate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    neg_sum == '0);
endmodule

// File: tb/otf_root_gen_bench.sv
`timescale 1ns/1ps
module otf_root_gen_bench;
  localparam int NDIG = 8;
  localparam int W    = 2 * NDIG;
  localparam int MW   = W + 3;
  localparam longint WMASK = (longint'(1) << W) - 1;
  localparam longint MMASK = (longint'(1) << MW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init = 1'b0, step = 1'b0, mode = 1'b1;
  logic [4:0] digit = 5'b00100;
  logic [W-1:0] divisor = '0;
  logic [W-1:0] q_pos, q_negn;
  logic done;
  logic [4:0][MW-1:0] mult;
  logic [4:0] cin;
  logic [MW-1:0] sel_mult;
  logic sel_cin;

  int checks = 0;
  int errors = 0;
  longint qv = 0;
  int kk = 0;
  int cur_q = 0;

  always #4 clk = ~clk;

  otf_root_gen #(.NDIG(NDIG)) u_otf_root_gen (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init), .step_i(step), .mode_i(mode),
    .digit_i(digit), .divisor_i(divisor), .q_pos_o(q_pos), .q_negn_o(q_negn),
    .done_o(done), .mult_o(mult), .cin_o(cin), .sel_mult_o(sel_mult),
    .sel_cin_o(sel_cin)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic longint next_weight();
    return (kk < NDIG) ? (longint'(1) << (2 * (NDIG - 1 - kk))) : 0;
  endfunction

  function automatic longint exp_neg_mult(input int c);
    longint s;
    if (mode) s = c * (2 * qv + c * next_weight());
    else      s = c * longint'(divisor);
    return (-s) & MMASK;
  endfunction

  task automatic check_all();
    chk("R2 q_pos", longint'(q_pos), qv & WMASK);
    chk("R3 q_negn", longint'(q_negn), (-qv) & WMASK);
    chk("R9 done", longint'(done), (kk >= NDIG) ? 1 : 0);
    for (int c = -2; c <= 2; c++) begin
      if (c == 0) begin
        chk("R6 zero mult", longint'(mult[2]), 0);
        chk("R6 zero cin", longint'(cin[2]), 0);
      end else if (mode) begin
        chk(c > 0 ? "R4 root pos mult" : "R5 root neg mult",
            (longint'(mult[c+2]) + longint'(cin[c+2])) & MMASK, exp_neg_mult(c));
        chk(c > 0 ? "R4 root cin" : "R5 root cin", longint'(cin[c+2]), 1);
      end else begin
        chk("R7 div mult", (longint'(mult[c+2]) + longint'(cin[c+2])) & MMASK,
            exp_neg_mult(c));
        chk("R7 div cin", longint'(cin[c+2]), (c > 0) ? 1 : 0);
      end
    end
    chk("R8 sel mult", longint'(sel_mult), longint'(mult[cur_q+2]));
    chk("R8 sel cin", longint'(sel_cin), longint'(cin[cur_q+2]));
  endtask

  // drive at negedge, update model at posedge, check 2ns later
  task automatic cycle(input logic i_init, input logic i_step, input int q,
                       input logic i_mode, input logic [W-1:0] d);
    @(negedge clk);
    init = i_init; step = i_step; mode = i_mode; divisor = d;
    cur_q = q;
    digit = 5'b00001 << (q + 2);
    @(posedge clk);
    if (i_init) begin
      qv = 0; kk = 0;
    end else if (i_step && kk < NDIG) begin
      qv = qv + q * next_weight();
      kk++;
    end
    #2;
    check_all();
  endtask

  function automatic int pick_digit();
    int q;
    q = int'($urandom_range(4)) - 2;
    if (qv + q * next_weight() < 0) q = -q;
    return q;
  endfunction

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog: got hang expected completion");
    finish_up();
  end

  initial begin
    int seed;
    seed = $urandom(32'd7321);
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk("R1 reset q_pos", longint'(q_pos), 0);
    chk("R1 reset q_negn", longint'(q_negn), 0);
    chk("R1 reset done", longint'(done), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // first digit negative-capable slot with Q zero (R5 sign extension)
    cycle(1'b0, 1'b0, 0, 1'b1, '0);

    // directed: all +2 in root mode (R2 R4)
    cycle(1'b1, 1'b0, 0, 1'b1, '0);
    for (int i = 0; i < NDIG; i++) cycle(1'b0, 1'b1, 2, 1'b1, '0);
    // R9 extra steps ignored
    for (int i = 0; i < 3; i++) cycle(1'b0, 1'b1, -2, 1'b1, '0);

    // directed: +1 then all -2 (R3 R5 reload from minus form)
    cycle(1'b1, 1'b0, 0, 1'b1, '0);
    cycle(1'b0, 1'b1, 1, 1'b1, '0);
    for (int i = 1; i < NDIG; i++) cycle(1'b0, 1'b1, -2, 1'b1, '0);

    // R1 init wins over step
    cycle(1'b0, 1'b0, 0, 1'b1, '0);
    cycle(1'b1, 1'b1, 2, 1'b1, '0);
    chk("R1 init priority", longint'(q_pos), 0);

    // R10 hold with step low, then R7 divide mode
    cycle(1'b0, 1'b1, 1, 1'b0, 16'h9a3c);
    for (int i = 0; i < 4; i++) cycle(1'b0, 1'b0, -1, 1'b0, W'($urandom));
    chk("R10 hold", longint'(q_pos), longint'(1) << (W - 2));

    // random runs
    for (int r = 0; r < 40; r++) begin
      logic md;
      md = 1'($urandom_range(1));
      cycle(1'b1, 1'b0, 0, md, W'($urandom));
      for (int i = 0; i < NDIG + 2; i++) begin
        logic st;
        st = ($urandom_range(3) != 0);
        cycle(1'b0, st, pick_digit(), md, W'($urandom));
      end
    end
    finish_up();
  end
endmodule